// File: doc/BRIEF.md
# Five-Channel PWM Tick Prescaler and Divider

This block turns a single base clock into five per-channel tick enables for a PWM timer. Two 8-bit prescalers share the channels unevenly: one feeds channels 0 and 1, the other feeds channels 2, 3 and 4. Each channel then applies its own 4-bit selector. The selector either divides its prescaler's ticks by a power of two, or hands the channel over to an external tick source shared by the channel's group.

Every output is a one-cycle enable in the base clock domain, never a derived clock. The counters and compare logic downstream use these enables as their step qualifiers. Software programs the block through a plain write/read register port with two words: the prescaler word and the selector word. Nothing in the block streams data, so it has no valid/ready handshake. The register port accepts a write on every cycle, and reads are combinational.

A prescaler write never shortens the tick interval that is in progress. The new value is loaded only when the running count reaches its terminal value.

Top module: `pwm_tick_gen`

## Requirements
- R1: After reset, both register words read back as zero, and all five tick outputs are high on every cycle (prescale 1, divide 1).
- R2: Prescaler word bits 7:0 hold value P0. Channels 0 and 1 then see a prescaler tick once every P0+1 base cycles.
- R3: Prescaler word bits 15:8 hold value P1. Channels 2, 3 and 4 use P1 with the same rule, independently of P0.
- R4: The selector word gives channel c the 4-bit code at bits 4c+3:4c (address 1). Prescaler writes use address 0. A code k that is not marked external divides the prescaler ticks by 2^(k+DIV_BASE), with DIV_BASE=0 by default. The selector word reads back as written.
- R5: A non-external code whose shift exceeds MAX_SHIFT (4) divides by 16, the largest supported divide.
- R6: Codes whose bit is set in EXT_MASK (codes 5, 6 and 7 by default) select the external tick. Channels 0 and 1 use ext_tick_i[0], and channels 2 to 4 use ext_tick_i[1]. The input passes through a two-flop synchroniser. Each rising edge then gives exactly one single-cycle tick.
- R7: A write to a prescaler field takes effect at that prescaler's next terminal count, so the interval in progress completes at its old length.
- R8: A prescaler write that lands in the same cycle as a terminal count is loaded at that terminal, so the very next interval already uses the new value.
- R9: Any write to the selector word restarts every channel's divide phase. With a prescaler of 1 and code k, the channel's first tick comes 2^k cycles after the cycle in which the write was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 prescaler word, 1 selector word |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address, same encoding as wr_addr |
| rd_data | output | 32 | Read data (combinational) |
| ext_tick_i | input | 2 | Asynchronous external tick sources, one per channel group |
| tick_o | output | 5 | Per-channel single-cycle tick enables |

## Verification
The case that needs care is a prescaler write that arrives in the same cycle as that prescaler's terminal count. Two actions then compete for the active value: loading the next interval and accepting the new setting. The bench waits until it sees a tick on channel 0, which is the terminal cycle, and presents the write in that same cycle. It then checks that the next interval has the new length, not the old one. A second run presents the write in the middle of an interval and checks that the running interval completes at its old length.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

  localparam int NUM_CH  = 5;
  localparam int NUM_GRP = 2;

  typedef enum logic {
    ADDR_PRESCALE = 1'b0,
    ADDR_SELECT   = 1'b1
  } reg_addr_e;

  // Channels 0..1 belong to group 0, channels 2..4 to group 1.
  function automatic int group_of(input int ch);
    return (ch < 2) ? 0 : 1;
  endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cfg_val,
  output logic         tick
);

  logic [W-1:0] pend_q, act_q, cnt_q;
  logic [W-1:0] pend_nx;

  assign pend_nx = wr_en ? wr_val : pend_q;
  assign tick    = (cnt_q == act_q);
  assign cfg_val = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_nx;
      if (tick) begin
        cnt_q <= '0;
        act_q <= pend_nx;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q); // R2
  AST_TERM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0)); // R7
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(act_q)); // R7

endmodule

// File: rtl/tk_ext_edge.sv
module tk_ext_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic pulse
);

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pulse = s2_q & ~s3_q;

  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R6

endmodule

// File: rtl/tk_chan_div.sv
module tk_chan_div #(
  parameter int                     SEL_W     = 4,
  parameter int                     MAX_SHIFT = 4,
  parameter int                     DIV_BASE  = 0,
  parameter logic [(1<<SEL_W)-1:0]  EXT_MASK  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  input  logic             pre_tick,
  input  logic             ext_pulse,
  output logic             tick
);

  logic [MAX_SHIFT-1:0] cnt_q;
  logic [MAX_SHIFT-1:0] mask;
  logic                 ext_sel;
  logic                 div_hit;
  int                   shamt;

  assign ext_sel = EXT_MASK[sel];

  always_comb begin
    shamt = int'(sel) + DIV_BASE;
    if (shamt > MAX_SHIFT) shamt = MAX_SHIFT;
    for (int i = 0; i < MAX_SHIFT; i++) mask[i] = (i < shamt);
  end

  assign div_hit = pre_tick && ((cnt_q & mask) == mask);
  assign tick    = ext_sel ? ext_pulse : div_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (pre_tick) cnt_q <= cnt_q + 1'b1;
  end

  AST_DIV_NEEDS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && tick) |-> pre_tick); // R4
  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int                    PRE_W     = 8,
  parameter int                    SEL_W     = 4,
  parameter int                    REG_W     = 32,
  parameter int                    DIV_BASE  = 0,
  parameter int                    MAX_SHIFT = 4,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK  = 16'h00E0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic                                 wr_addr,
  input  logic [REG_W-1:0]                     wr_data,
  input  logic                                 rd_addr,
  output logic [REG_W-1:0]                     rd_data,
  input  logic [pwm_tick_pkg::NUM_GRP-1:0]     ext_tick_i,
  output logic [pwm_tick_pkg::NUM_CH-1:0]      tick_o
);
  import pwm_tick_pkg::*;

  localparam int PRE_TOT = NUM_GRP * PRE_W;
  localparam int SEL_TOT = NUM_CH * SEL_W;

  logic               pre_wr, sel_wr;
  logic [PRE_TOT-1:0] pre_cfg;
  logic [NUM_GRP-1:0] pre_tick, ext_pulse;
  logic [SEL_TOT-1:0] sel_q;

  assign pre_wr = wr_en && (wr_addr == ADDR_PRESCALE);
  assign sel_wr = wr_en && (wr_addr == ADDR_SELECT);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= wr_data[SEL_TOT-1:0];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tk_prescaler #(.W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pre_wr),
      .wr_val  (wr_data[g*PRE_W +: PRE_W]),
      .cfg_val (pre_cfg[g*PRE_W +: PRE_W]),
      .tick    (pre_tick[g])
    );
    tk_ext_edge u_ext (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_tick_i[g]),
      .pulse   (ext_pulse[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = group_of(c);
    tk_chan_div #(
      .SEL_W     (SEL_W),
      .MAX_SHIFT (MAX_SHIFT),
      .DIV_BASE  (DIV_BASE),
      .EXT_MASK  (EXT_MASK)
    ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel_q[c*SEL_W +: SEL_W]),
      .restart   (sel_wr),
      .pre_tick  (pre_tick[GRP]),
      .ext_pulse (ext_pulse[GRP]),
      .tick      (tick_o[c])
    );
  end

  always_comb begin
    if (rd_addr == ADDR_PRESCALE) rd_data = {{(REG_W-PRE_TOT){1'b0}}, pre_cfg};
    else                          rd_data = {{(REG_W-SEL_TOT){1'b0}}, sel_q};
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q)); // R4
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q == $past(wr_data[SEL_TOT-1:0]))); // R4

endmodule

// File: tb/pwm_tick_gen_test.sv
module pwm_tick_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  ext_tick_i = '0;
  logic [4:0]  tick_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic ext0_run = 1'b0, ext1_run = 1'b0;

  // Scoreboard: expected periods per channel
  int    exp_ch[$];
  int    exp_per[$];
  string exp_tag[$];

  pwm_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_tick_i(ext_tick_i), .tick_o(tick_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (7) @(negedge clk);
    if (ext0_run) ext_tick_i[0] = ~ext_tick_i[0];
  end
  initial forever begin
    repeat (5) @(negedge clk);
    if (ext1_run) ext_tick_i[1] = ~ext_tick_i[1];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic addr, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = addr; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic next_tick(input int ch, output int t);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!tick_o[ch] && guard < 3000);
    if (guard >= 3000) check(1'b0, "watch", ch, -1);
    t = cyc;
  endtask

  task automatic push_exp(input int ch, input int per, input string tag);
    exp_ch.push_back(ch); exp_per.push_back(per); exp_tag.push_back(tag);
  endtask

  // Monitor: pops expectations and measures the steady tick interval
  task automatic drain();
    while (exp_ch.size() > 0) begin
      int ch, per, t0, t1;
      string tag;
      ch = exp_ch.pop_front(); per = exp_per.pop_front(); tag = exp_tag.pop_front();
      next_tick(ch, t0);
      next_tick(ch, t0);
      next_tick(ch, t1);
      check((t1 - t0) == per, tag, t1 - t0, per);
    end
  endtask

  initial begin
    int t0, t1, t2, cw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd_addr = 1'b0; #1;
    check(rd_data == 0, "R1 prescale word", int'(rd_data), 0);
    rd_addr = 1'b1; #1;
    check(rd_data == 0, "R1 select word", int'(rd_data), 0);
    @(negedge clk);
    check(tick_o == 5'b11111, "R1 ticks every cycle", int'(tick_o), 31);

    // R2 / R3: prescalers, selector 0
    reg_write(1'b0, 32'h0000_0003);
    push_exp(0, 4, "R2 ch0 P0=3"); push_exp(1, 4, "R2 ch1 P0=3");
    push_exp(2, 1, "R3 ch2 P1=0"); push_exp(4, 1, "R3 ch4 P1=0");
    drain();
    rd_addr = 1'b0; #1;
    check(rd_data == 32'h3, "R2 readback", int'(rd_data), 3);

    // R4: per-channel codes; field c at bits 4c+3:4c
    reg_write(1'b0, 32'h0000_0401);
    reg_write(1'b1, 32'h0004_2310);
    rd_addr = 1'b1; #1;
    check(rd_data == 32'h0004_2310, "R4 select readback", int'(rd_data), 32'h42310);
    push_exp(0, 2,  "R3 ch0 code0 P0=1");
    push_exp(1, 4,  "R4 ch1 code1");
    push_exp(2, 40, "R4 ch2 code3 P1=4");
    push_exp(3, 20, "R4 ch3 code2 P1=4");
    push_exp(4, 80, "R4 ch4 code4 P1=4");
    drain();

    // R5: codes beyond the largest shift clamp to 16
    reg_write(1'b0, 32'h0000_0001);
    reg_write(1'b1, 32'h000F_0090);
    push_exp(1, 32, "R5 ch1 code9 P0=1");
    push_exp(4, 16, "R5 ch4 code15 P1=0");
    drain();

    // R6: external ticks, group mapping
    reg_write(1'b0, 32'h0000_0002);
    reg_write(1'b1, 32'h0000_6005);
    ext0_run = 1'b1; ext1_run = 1'b1;
    push_exp(0, 14, "R6 ch0 ext0");
    push_exp(3, 10, "R6 ch3 ext1");
    push_exp(1, 3,  "R6 ch1 divider untouched");
    drain();
    ext0_run = 1'b0; ext1_run = 1'b0;

    // R7: mid-interval prescaler write does not shorten the running interval
    reg_write(1'b1, 32'h0000_0000);
    reg_write(1'b0, 32'h0000_0009);
    push_exp(0, 10, "R7 setup P0=9");
    drain();
    next_tick(0, t0);
    repeat (3) @(negedge clk);
    reg_write(1'b0, 32'h0000_0001);
    next_tick(0, t1);
    check((t1 - t0) == 10, "R7 running interval kept", t1 - t0, 10);
    next_tick(0, t2);
    check((t2 - t1) == 2, "R7 new value after terminal", t2 - t1, 2);

    // R8: write in the terminal cycle is taken at once
    reg_write(1'b0, 32'h0000_0009);
    push_exp(0, 10, "R8 setup P0=9");
    drain();
    next_tick(0, t0);
    reg_write(1'b0, 32'h0000_0002);
    next_tick(0, t1);
    check((t1 - t0) == 3, "R8 write at terminal", t1 - t0, 3);

    // R9: selector write restarts the divide phase
    reg_write(1'b0, 32'h0000_0000);
    push_exp(0, 1, "R9 setup P0=0");
    drain();
    cw = cyc;
    reg_write(1'b1, 32'h0000_0002);
    next_tick(0, t1);
    check((t1 - cw) == 4, "R9 first tick after restart", t1 - cw, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule